// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block connects the four level-sensitive PCI interrupt pins to a bank of sixteen request lines that feed a legacy interrupt controller. Each pin has a 4-bit IRQ number that selects the line it drives. An output line is high while at least one pin routed to it is high. The routing fields sit in three byte-wide configuration registers, and a small register port writes and reads them.

The routing fields are nibbles at fixed byte addresses, and their layout is irregular. The middle byte holds two fields. The first and last bytes each hold one field in their upper half, and their lower halves are plain storage that routing never uses. An IRQ number of 0 leaves a pin unconnected. The numbers 2 and 15 are reserved, so a pin routed to either of them drives nothing. The pin inputs pass through a two-stage synchronizer, and the output vector is registered.

Top module: `pci_irq_router`

## Requirements
- R1: After reset, all three routing bytes read 0x00 and `irq_out` is all zeros. This holds whatever levels the pins have.
- R2: Bytes at addresses 0x55, 0x56 and 0x57 store all 8 written bits. `cfg_rdata` shows the byte at the address sampled at the previous clock edge.
- R3: Every other address reads 0x00. A write to any other address changes no stored byte.
- R4: The field layout is as follows:
  - pin 0 uses bits [7:4] of 0x55;
  - pin 1 uses bits [3:0] of 0x56;
  - pin 2 uses bits [7:4] of 0x56;
  - pin 3 uses bits [7:4] of 0x57.
  The lower nibbles of 0x55 and 0x57 have no effect on routing.
- R5: A pin whose IRQ number is 0 drives no output line.
- R6: A pin whose IRQ number is 2 or 15 drives no output line. Bits 0, 2 and 15 of `irq_out` are never set.
- R7: Output line k is the OR of the levels of all pins whose valid IRQ number is k. Pins that share a line combine; one does not override another.
- R8: A routing write takes effect one cycle after the write edge. The old line drops unless another pin still holds it, and the new line rises.
- R9: A pin level change appears on `irq_out` at the third rising edge after the change (two synchronizer stages plus the output register).
- R10: Routing is level based. When every pin mapped to a line falls, that line falls after the same latency. With all pins low, `irq_out` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 4 | PCI interrupt pin levels, active high |
| cfg_addr | input | 8 | Register port byte address |
| cfg_wr_en | input | 1 | Write strobe for `cfg_wdata` at `cfg_addr` |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data |
| irq_out | output | 16 | Request lines to the interrupt controller |

## Verification
The bench builds the router with its default parameters:
- four pins;
- sixteen lines;
- a three-byte window based at 0x55;
- two synchronizer stages.

With these values every IRQ number from 0 to 15 can be written, so both reserved codes and both edge values (1 and 14) are reachable. The two-cycle synchronizer latency is exposed and is checked cycle by cycle. Shared routes and route moves while another pin holds the line are driven directly. Addresses just outside the window on each side test the window decode.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  localparam int ROUTE_W = 4;

  // Bit offset of each pin's route nibble inside the flattened window
  // (byte 0 at bits [7:0]); the layout is irregular and fixed.
  function automatic int route_lsb(input int pin);
    case (pin)
      0:       return 4;
      1:       return 8;
      2:       return 12;
      3:       return 20;
      default: return 0;
    endcase
  endfunction

  // Zero disconnects, code 2 and the top line are reserved.
  function automatic logic route_ok(input logic [ROUTE_W-1:0] r, input int lines);
    return (r != '0) && (r != ROUTE_W'(2)) && (int'(r) < lines - 1);
  endfunction

endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= '0;
          else     stage[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[s] <= '0;
          else     stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];

endmodule

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs #(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 8,
  parameter int              NUM_REGS  = 3,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h55,
  localparam int             IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int             FLAT_W    = NUM_REGS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [FLAT_W-1:0] cfg_flat
);

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] rd_q;
  logic              hit;
  logic [IDX_W-1:0]  idx;

  assign hit = (addr >= BASE_ADDR) && ({1'b0, addr} < ({1'b0, BASE_ADDR} + (ADDR_W+1)'(NUM_REGS)));
  assign idx = IDX_W'(addr - BASE_ADDR);

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)                                    regs[i] <= '0;
        else if (wr_en && hit && (idx == IDX_W'(i))) regs[i] <= wdata;
      end
      assign cfg_flat[i*DATA_W +: DATA_W] = regs[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)      rd_q <= '0;
    else if (hit) rd_q <= regs[idx];
    else          rd_q <= '0;
  end

  assign rdata = rd_q;

  // R1
  reset_read_zero_chk: assert property (@(posedge clk) rst |=> (rd_q == '0));
  // R2
  write_store_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit) |=> (regs[$past(idx)] == $past(wdata)));
  // R3
  outside_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |=> (rd_q == '0));
  // R3
  outside_write_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && hit) |=> (cfg_flat == $past(cfg_flat)));

endmodule

// File: rtl/pirq_route_map.sv
module pirq_route_map
  import pirq_pkg::*;
#(
  parameter int NUM_PINS  = 4,
  parameter int NUM_LINES = 16,
  parameter int CFG_W     = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CFG_W-1:0]     cfg_flat,
  input  logic [NUM_PINS-1:0]  pins,
  output logic [NUM_LINES-1:0] irq
);

  logic [NUM_LINES-1:0] hit [NUM_PINS];
  logic [NUM_LINES-1:0] merged;
  logic [NUM_LINES-1:0] irq_q;

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic [ROUTE_W-1:0]   route;
      logic                 valid;
      logic [NUM_LINES-1:0] onehot;
      assign route  = cfg_flat[route_lsb(p) +: ROUTE_W];
      assign valid  = route_ok(route, NUM_LINES);
      assign onehot = {{(NUM_LINES-1){1'b0}}, 1'b1} << route;
      assign hit[p] = (valid && pins[p]) ? onehot : '0;
    end
  endgenerate

  always_comb begin
    merged = '0;
    for (int p = 0; p < NUM_PINS; p++) merged = merged | hit[p];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= merged;
  end

  assign irq = irq_q;

  // R1
  reset_irq_zero_chk: assert property (@(posedge clk) rst |=> (irq_q == '0));
  // R6
  reserved_lines_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_q[0] == 1'b0) && (irq_q[2] == 1'b0) && (irq_q[NUM_LINES-1] == 1'b0));
  // R10
  idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
    (pins == '0) |=> (irq_q == '0));
  // R7
  active_count_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(irq_q) <= NUM_PINS);

endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pirq_pkg::*;
#(
  parameter int          NUM_PINS    = 4,
  parameter int          NUM_LINES   = 16,
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 8,
  parameter int          NUM_REGS    = 3,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  BASE_ADDR   = 8'h55,
  localparam int         CFG_W       = NUM_REGS * DATA_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PINS-1:0]  pin_in,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic                 cfg_wr_en,
  input  logic [DATA_W-1:0]    cfg_wdata,
  output logic [DATA_W-1:0]    cfg_rdata,
  output logic [NUM_LINES-1:0] irq_out
);

  logic [NUM_PINS-1:0] pins_s;
  logic [CFG_W-1:0]    cfg_flat;

  pirq_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pins_s)
  );

  pirq_cfg_regs #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_REGS  (NUM_REGS),
    .BASE_ADDR (ADDR_W'(BASE_ADDR))
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .addr     (cfg_addr),
    .wr_en    (cfg_wr_en),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .cfg_flat (cfg_flat)
  );

  pirq_route_map #(
    .NUM_PINS  (NUM_PINS),
    .NUM_LINES (NUM_LINES),
    .CFG_W     (CFG_W)
  ) u_map (
    .clk      (clk),
    .rst      (rst),
    .cfg_flat (cfg_flat),
    .pins     (pins_s),
    .irq      (irq_out)
  );

endmodule

// File: tb/pci_irq_router_bench.sv
module pci_irq_router_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  pin_in = '0;
  logic [7:0]  cfg_addr = '0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [15:0] irq_out;

  always #2.5 clk = ~clk;

  pci_irq_router u_pci_irq_router (
    .clk       (clk),
    .rst       (rst),
    .pin_in    (pin_in),
    .cfg_addr  (cfg_addr),
    .cfg_wr_en (cfg_wr_en),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .irq_out   (irq_out)
  );

  typedef struct {
    bit          is_rd;
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t sb[$];
  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] shadow [3] = '{8'h00, 8'h00, 8'h00};
  logic [3:0] lvl = '0;

  // Expected lines from the stated layout: pin0 0x55[7:4], pin1 0x56[3:0],
  // pin2 0x56[7:4], pin3 0x57[7:4]; codes 0, 2, 15 drive nothing.
  function automatic logic [15:0] model();
    logic [15:0] v = '0;
    logic [3:0]  r [4];
    r[0] = shadow[0][7:4];
    r[1] = shadow[1][3:0];
    r[2] = shadow[1][7:4];
    r[3] = shadow[2][7:4];
    for (int p = 0; p < 4; p++)
      if (lvl[p] && r[p] != 0 && r[p] != 2 && r[p] != 15) v[r[p]] = 1'b1;
    return v;
  endfunction

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_checks++;
      if (it.is_rd) begin
        if (cfg_rdata !== it.exp[7:0]) begin
          n_fail++;
          $display("FAIL %s: cfg_rdata=%h expected %h", it.req, cfg_rdata, it.exp[7:0]);
        end
      end else if (irq_out !== it.exp) begin
        n_fail++;
        $display("FAIL %s: irq_out=%h expected %h", it.req, irq_out, it.exp);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic push_irq(input logic [15:0] e, input string req);
    item_t it;
    it.is_rd = 1'b0; it.exp = e; it.req = req;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_wr_en = 1'b1;
    step(1);
    cfg_wr_en = 1'b0;
    if (a >= 8'h55 && a <= 8'h57) shadow[a - 8'h55] = d;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string req);
    item_t it;
    cfg_addr = a;
    step(1);
    it.is_rd = 1'b1; it.exp = {8'h00, e}; it.req = req;
    sb.push_back(it);
  endtask

  task automatic pins(input logic [3:0] v, input string req);
    pin_in = v;
    step(3);
    lvl = v;
    push_irq(model(), req);
  endtask

  task automatic wr_route(input logic [7:0] a, input logic [7:0] d, input string req);
    wr(a, d);
    step(1);
    push_irq(model(), req);
  endtask

  initial begin
    pin_in = 4'b1111;
    step(3);
    rst = 1'b0;
    push_irq(16'h0000, "R1 irq after reset");
    rd(8'h55, 8'h00, "R1 byte 0x55");
    rd(8'h56, 8'h00, "R1 byte 0x56");
    rd(8'h57, 8'h00, "R1 byte 0x57");
    step(3);
    push_irq(16'h0000, "R1 pins high, routes zero");
    pins(4'b0000, "R10 idle");

    wr(8'h55, 8'hA3);
    rd(8'h55, 8'hA3, "R2 readback 0x55");
    // R9: latency of three edges
    pin_in = 4'b0001;
    step(2);
    push_irq(16'h0000, "R9 not yet after two edges");
    step(1);
    lvl = 4'b0001;
    push_irq(16'h0400, "R9 R4 pin0 on line 10");

    wr(8'h56, 8'h5B);
    wr(8'h57, 8'h7C);
    rd(8'h56, 8'h5B, "R2 readback 0x56");
    rd(8'h57, 8'h7C, "R2 readback 0x57");
    step(1);
    pins(4'b1111, "R4 all four pins");
    push_irq(16'h0CA0, "R4 lines 5,7,10,11 literal");

    // R7 sharing
    wr_route(8'h56, 8'hAA, "R7 pins 0,1,2 share line 10");
    pins(4'b0110, "R7 pins 1,2 shared");
    pins(4'b0100, "R7 one holder left");
    pins(4'b0000, "R10 all fall");
    push_irq(16'h0000, "R10 literal zero");

    // R8 route moves
    pins(4'b0001, "R8 setup");
    wr_route(8'h55, 8'h60, "R8 move pin0 to line 6");
    push_irq(16'h0040, "R8 literal line 6");
    pins(4'b0011, "R8 setup shared");
    wr_route(8'h55, 8'h30, "R8 line 10 held by pin1");
    push_irq(16'h0408, "R8 literal lines 3,10");

    // R5 R6
    pins(4'b1111, "R5 setup");
    wr_route(8'h55, 8'h00, "R5 pin0 route zero");
    wr_route(8'h56, 8'h2F, "R6 codes 15 and 2");
    wr_route(8'h57, 8'hE0, "R6 edge code 14");
    push_irq(16'h4000, "R6 literal line 14 only");
    wr_route(8'h55, 8'h10, "R6 edge code 1");
    push_irq(16'h4002, "R6 literal lines 1,14");
    wr_route(8'h57, 8'hF5, "R6 pin3 code 15");
    push_irq(16'h0002, "R4 R6 lower nibble ignored");

    // R3 outside window
    wr(8'h54, 8'hFF);
    wr(8'h58, 8'hFF);
    wr(8'h00, 8'hFF);
    rd(8'h54, 8'h00, "R3 0x54 reads zero");
    rd(8'h58, 8'h00, "R3 0x58 reads zero");
    rd(8'h55, 8'h10, "R3 0x55 untouched");
    rd(8'h56, 8'h2F, "R3 0x56 untouched");
    rd(8'h57, 8'hF5, "R3 0x57 untouched");
    step(1);
    push_irq(16'h0002, "R3 outputs untouched");

    // R1 mid-run reset
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    shadow = '{8'h00, 8'h00, 8'h00};
    push_irq(16'h0000, "R1 irq after second reset");
    rd(8'h55, 8'h00, "R1 0x55 cleared");
    rd(8'h56, 8'h00, "R1 0x56 cleared");
    step(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule